// File: doc/BRIEF.md
# Bus Response Timeout Monitor

This block watches every bus cycle for a data-transfer acknowledge. When a bus cycle starts, a counter begins. If the acknowledge does not arrive within the allowed number of clocks, the block raises a one-clock internal bus error strobe. Cycles aimed at on-chip resources are always timed, against a fixed limit. Cycles that go off chip can be timed against one of four selectable limits, or left untimed.

The same tracker also runs a spurious-interrupt check on interrupt-acknowledge cycles. If no arbitration response is seen within a short window, or the cycle is acknowledged before any arbitration response, the block raises the same internal error. This check cannot be switched off. The error never leaves the block as a pin. The surrounding bus controller uses the strobe to end the stalled cycle.

Edge numbering used below: the rising edge that samples `cyc_start` high is edge 0. An error "at edge k" means that `bus_err` is high for the one clock that follows edge k.

Top module: `bus_resp_monitor`

## Requirements
- R1: A cycle with `cyc_ext`=0 is always timed with a limit of 64 clocks. If `ack` is not sampled high on any of edges 1..64, `bus_err` pulses at edge 64.
- R2: A cycle with `cyc_ext`=1 and `ext_mon_en`=1 is timed with the limit selected by `ext_lim_sel`: 0 selects 8 clocks, 1 selects 16, 2 selects 32 and 3 selects 64. The error comes at the edge equal to the limit.
- R3: A cycle with `cyc_ext`=1, `ext_mon_en`=0 and `cyc_iack`=0 never raises `bus_err`, however long the acknowledge takes.
- R4: `ack` sampled on an edge up to and including the limit edge ends the cycle without error. On that same edge, `ack` takes priority over the timeout.
- R5: In a cycle with `cyc_iack`=1, `bus_err` pulses at edge 4 if `arb_resp` has not been sampled high on edges 1..4. It also pulses on an earlier edge where `ack` is sampled with no `arb_resp` seen so far. An `arb_resp` sampled on the same edge as `ack` counts as seen. Once arbitration is seen, the normal timeout of R1/R2/R3 applies.
- R6: The spurious-interrupt check of R5 applies whatever the values of `cyc_ext` and `ext_mon_en`.
- R7: `bus_err` is high for exactly one clock, and at most once per bus cycle. A new `cyc_start` restarts timing, cancels the old cycle, and gives no error on its own edge.
- R8: `cyc_ext`, `cyc_iack`, `ext_mon_en` and `ext_lim_sel` are sampled only on the `cyc_start` edge. Changing them during a cycle has no effect on that cycle.
- R9: While `rst_n` is low, `bus_err` is low. A cycle in progress at reset is abandoned and never raises an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | One-clock marker of a new bus cycle |
| cyc_ext | input | 1 | Cycle targets off-chip space (sampled at start) |
| cyc_iack | input | 1 | Cycle is an interrupt acknowledge (sampled at start) |
| ack | input | 1 | Data-transfer acknowledge for the current cycle |
| arb_resp | input | 1 | Interrupt arbitration response seen |
| ext_mon_en | input | 1 | Enable timing of off-chip cycles (sampled at start) |
| ext_lim_sel | input | 2 | Off-chip limit select: 8/16/32/64 clocks (sampled at start) |
| bus_err | output | 1 | Internal bus error strobe, one clock wide |

## Verification
Every result appears one clock after the edge that decides it, because `bus_err` comes from a single register. A timeout therefore shows in the clock after edge L, where L is the selected limit. A spurious acknowledge shows after edge 4, or after the edge that sampled the early `ack`. The bench drives inputs and samples `bus_err` on falling edges. It numbers the rising edges from the start edge and records on which edge the first pulse was seen and how many pulses came. It then compares both against the edge worked out from the limit for that vector.

// File: rtl/bm_pkg.sv
// Package: shared types and helpers for the bus response timeout monitor.
// Assumes a 2-bit external limit select, which gives four limit choices.
package bm_pkg;

    localparam int SEL_W = 2;
    localparam int SEL_N = 1 << SEL_W;

    // Attributes of a bus cycle, captured on its start edge
    typedef struct packed {
        logic             ext;    // off-chip target
        logic             iack;   // interrupt acknowledge cycle
        logic             timed;  // acknowledge timeout applies
        logic [SEL_W-1:0] sel;    // off-chip limit select
    } cyc_ctx_t;

    // Largest of two integers, used when sizing counters
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/bm_cycle_ctx.sv
// Module: bm_cycle_ctx
// Captures the attributes of each bus cycle on its start edge and tracks
// whether a cycle is open and whether arbitration has been seen in it.
// Assumes cyc_start is a one-clock marker. A start always wins over an end
// in the same clock.
module bm_cycle_ctx
    import bm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_ext,
    input  logic             cyc_iack,
    input  logic             ext_mon_en,
    input  logic [SEL_W-1:0] ext_lim_sel,
    input  logic             arb_resp,
    input  logic             cyc_end,
    output cyc_ctx_t         ctx,
    output logic             active,
    output logic             arb_seen
);

    cyc_ctx_t ctx_next;

    // Work out the timing rule for the cycle being started
    always_comb begin
        ctx_next.ext   = cyc_ext;
        ctx_next.iack  = cyc_iack;
        ctx_next.timed = !cyc_ext || ext_mon_en;
        ctx_next.sel   = ext_lim_sel;
    end

    // Hold the cycle attributes from one start edge to the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx <= '0;
        end else if (cyc_start) begin
            ctx <= ctx_next;
        end
    end

    // Open a cycle on start, close it on acknowledge or error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
        end else if (cyc_start) begin
            active <= 1'b1;
        end else if (cyc_end) begin
            active <= 1'b0;
        end
    end

    // Remember an arbitration response within the open cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arb_seen <= 1'b0;
        end else if (cyc_start) begin
            arb_seen <= 1'b0;
        end else if (active && arb_resp) begin
            arb_seen <= 1'b1;
        end
    end

endmodule

// File: rtl/bm_limit_sel.sv
// Module: bm_limit_sel
// Turns the captured cycle attributes into the last count value that is
// still in time. Off-chip limits double with each select step from BASE_LIM.
// On-chip cycles use INT_LIM. Assumes every limit is at least 1.
module bm_limit_sel
    import bm_pkg::*;
#(
    parameter int BASE_LIM = 8,
    parameter int INT_LIM  = 64,
    parameter int CNT_W    = 7
) (
    input  cyc_ctx_t         ctx,
    output logic [CNT_W-1:0] last_cnt
);

    logic [CNT_W-1:0] ext_last [SEL_N];

    // Build the table of off-chip limits, one entry per select code
    generate
        for (genvar g = 0; g < SEL_N; g++) begin : g_ext_lim
            assign ext_last[g] = CNT_W'((BASE_LIM << g) - 1);
        end
    endgenerate

    // Choose between the on-chip limit and the selected off-chip limit
    always_comb begin
        if (ctx.ext) begin
            last_cnt = ext_last[ctx.sel];
        end else begin
            last_cnt = CNT_W'(INT_LIM - 1);
        end
    end

endmodule

// File: rtl/bm_resp_timer.sv
// Module: bm_resp_timer
// Counts clocks since the start edge of the open cycle. It flags a timeout
// when the count reaches the last in-time value with no acknowledge. The
// count saturates, so untimed cycles may run forever.
module bm_resp_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             active,
    input  logic             timed,
    input  logic             ack,
    input  logic [CNT_W-1:0] last_cnt,
    output logic [CNT_W-1:0] cnt,
    output logic             timeout_hit
);

    localparam logic [CNT_W-1:0] CNT_SAT = '1;

    // Restart on every start edge; count while the cycle is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cyc_start) begin
            cnt <= '0;
        end else if (active && cnt != CNT_SAT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The limit is passed when this edge is the limit edge and no ack came
    always_comb begin
        timeout_hit = active && timed && !ack && (cnt == last_cnt);
    end

endmodule

// File: rtl/bm_arb_check.sv
// Module: bm_arb_check
// Spurious-interrupt check for interrupt-acknowledge cycles. It flags an
// error if no arbitration response has been seen by the end of the window,
// or if the cycle is acknowledged before any response. This check has no
// enable input.
module bm_arb_check #(
    parameter int ARB_WIN = 4,
    parameter int CNT_W   = 7
) (
    input  logic             active,
    input  logic             iack,
    input  logic             arb_seen,
    input  logic             arb_resp,
    input  logic             ack,
    input  logic [CNT_W-1:0] cnt,
    output logic             spur_hit
);

    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(ARB_WIN - 1);

    logic no_arb;
    logic win_end;

    // Arbitration absent so far, counting the current edge
    always_comb begin
        no_arb  = !arb_seen && !arb_resp;
        win_end = (cnt == WIN_LAST);
    end

    // Spurious when the window closes or the ack comes with no arbitration
    always_comb begin
        spur_hit = active && iack && no_arb && (ack || win_end);
    end

endmodule

// File: rtl/bus_resp_monitor.sv
// Module: bus_resp_monitor (top)
// Bus response timeout monitor. It times the acknowledge of each bus cycle
// and checks interrupt-acknowledge cycles for an arbitration response. It
// raises a one-clock internal error strobe. Assumes cyc_start marks each
// cycle for one clock, and that ARB_WIN is below every timeout limit.
module bus_resp_monitor
    import bm_pkg::*;
#(
    parameter int BASE_LIM = 8,
    parameter int INT_LIM  = 64,
    parameter int ARB_WIN  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_start,
    input  logic             cyc_ext,
    input  logic             cyc_iack,
    input  logic             ack,
    input  logic             arb_resp,
    input  logic             ext_mon_en,
    input  logic [SEL_W-1:0] ext_lim_sel,
    output logic             bus_err
);

    localparam int EXT_MAX = BASE_LIM << (SEL_N - 1);
    localparam int MAX_LIM = imax(imax(EXT_MAX, INT_LIM), ARB_WIN);
    localparam int CNT_W   = $clog2(MAX_LIM + 1);

    cyc_ctx_t         ctx;
    logic             cyc_active;
    logic             arb_seen;
    logic             cyc_end;
    logic             err_now;
    logic             timeout_hit;
    logic             spur_hit;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    bm_cycle_ctx u_ctx (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_ext     (cyc_ext),
        .cyc_iack    (cyc_iack),
        .ext_mon_en  (ext_mon_en),
        .ext_lim_sel (ext_lim_sel),
        .arb_resp    (arb_resp),
        .cyc_end     (cyc_end),
        .ctx         (ctx),
        .active      (cyc_active),
        .arb_seen    (arb_seen)
    );

    bm_limit_sel #(
        .BASE_LIM (BASE_LIM),
        .INT_LIM  (INT_LIM),
        .CNT_W    (CNT_W)
    ) u_lim (
        .ctx      (ctx),
        .last_cnt (last_cnt)
    );

    bm_resp_timer #(
        .CNT_W (CNT_W)
    ) u_tmr (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .active      (cyc_active),
        .timed       (ctx.timed),
        .ack         (ack),
        .last_cnt    (last_cnt),
        .cnt         (cnt),
        .timeout_hit (timeout_hit)
    );

    bm_arb_check #(
        .ARB_WIN (ARB_WIN),
        .CNT_W   (CNT_W)
    ) u_arb (
        .active   (cyc_active),
        .iack     (ctx.iack),
        .arb_seen (arb_seen),
        .arb_resp (arb_resp),
        .ack      (ack),
        .cnt      (cnt),
        .spur_hit (spur_hit)
    );

    // A new start cancels any error the old cycle would raise on this edge
    always_comb begin
        err_now = (timeout_hit || spur_hit) && !cyc_start;
        cyc_end = err_now || (cyc_active && ack);
    end

    // Register the error strobe; the cycle closes with it, so it is one clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err <= 1'b0;
        end else begin
            bus_err <= err_now;
        end
    end

endmodule

// File: rtl/bm_checker.sv
// Module: bm_checker
// Property checks for bus_resp_monitor, attached to it through bind below.
module bm_checker (
    input logic clk,
    input logic rst_n,
    input logic cyc_start,
    input logic ack,
    input logic arb_resp,
    input logic bus_err,
    input logic cyc_active,
    input logic arb_seen,
    input logic ctx_ext,
    input logic ctx_iack,
    input logic ctx_timed
);

    AST_ERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);  // R7

    AST_START_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_start |=> !bus_err);  // R7

    AST_ERR_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_err) |-> $past(cyc_active));  // R7

    AST_ACK_IN_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && ack && (!ctx_iack || arb_seen || arb_resp)) |=> !bus_err);  // R4

    AST_EXT_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && ctx_ext && !ctx_timed && !ctx_iack) |=> !bus_err);  // R3

endmodule

bind bus_resp_monitor bm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .ack        (ack),
    .arb_resp   (arb_resp),
    .bus_err    (bus_err),
    .cyc_active (cyc_active),
    .arb_seen   (arb_seen),
    .ctx_ext    (ctx.ext),
    .ctx_iack   (ctx.iack),
    .ctx_timed  (ctx.timed)
);

// File: tb/bus_resp_monitor_tb.sv
module bus_resp_monitor_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCH      = 80;
    localparam int WD_CYCLES  = 20000;

    typedef struct packed {
        logic [7:0] req;       // requirement number, for the message
        logic       ext;
        logic       iack;
        logic       mon;
        logic [1:0] sel;
        logic [7:0] ack_edge;  // 0 = never acknowledged
        logic [7:0] arb_edge;  // 0 = no arbitration
        logic [7:0] err_edge;  // 0 = no error expected
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{8'd4, 1'b0, 1'b0, 1'b1, 2'd0, 8'd5,  8'd0, 8'd0 },  // R4 on-chip ack early
        '{8'd1, 1'b0, 1'b0, 1'b1, 2'd0, 8'd0,  8'd0, 8'd64},  // R1 on-chip timeout
        '{8'd1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0, 8'd64},  // R1 ext enable ignored on-chip
        '{8'd4, 1'b0, 1'b0, 1'b1, 2'd0, 8'd64, 8'd0, 8'd0 },  // R4 ack on limit edge
        '{8'd2, 1'b1, 1'b0, 1'b1, 2'd0, 8'd0,  8'd0, 8'd8 },  // R2 sel 0
        '{8'd4, 1'b1, 1'b0, 1'b1, 2'd0, 8'd8,  8'd0, 8'd0 },  // R4 ack at 8
        '{8'd2, 1'b1, 1'b0, 1'b1, 2'd0, 8'd9,  8'd0, 8'd8 },  // R2 ack one late
        '{8'd2, 1'b1, 1'b0, 1'b1, 2'd1, 8'd0,  8'd0, 8'd16},  // R2 sel 1
        '{8'd2, 1'b1, 1'b0, 1'b1, 2'd2, 8'd0,  8'd0, 8'd32},  // R2 sel 2
        '{8'd2, 1'b1, 1'b0, 1'b1, 2'd3, 8'd0,  8'd0, 8'd64},  // R2 sel 3
        '{8'd3, 1'b1, 1'b0, 1'b0, 2'd0, 8'd0,  8'd0, 8'd0 },  // R3 ext untimed
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd3,  8'd2, 8'd0 },  // R5 normal iack
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd0,  8'd0, 8'd4 },  // R5 window closes
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd2,  8'd0, 8'd2 },  // R5 ack before arb
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd3,  8'd3, 8'd0 },  // R5 arb with ack
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd6,  8'd4, 8'd0 },  // R5 arb on last window edge
        '{8'd6, 1'b1, 1'b1, 1'b0, 2'd0, 8'd0,  8'd0, 8'd4 },  // R6 check with ext off
        '{8'd5, 1'b0, 1'b1, 1'b1, 2'd0, 8'd0,  8'd2, 8'd64}   // R5 timeout after arb
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_start = 1'b0;
    logic       cyc_ext = 1'b0;
    logic       cyc_iack = 1'b0;
    logic       ack = 1'b0;
    logic       arb_resp = 1'b0;
    logic       ext_mon_en = 1'b0;
    logic [1:0] ext_lim_sel = 2'd0;
    logic       bus_err;

    int n_checks = 0;
    int n_fail   = 0;

    bus_resp_monitor u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_start   (cyc_start),
        .cyc_ext     (cyc_ext),
        .cyc_iack    (cyc_iack),
        .ack         (ack),
        .arb_resp    (arb_resp),
        .ext_mon_en  (ext_mon_en),
        .ext_lim_sel (ext_lim_sel),
        .bus_err     (bus_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Start a cycle; returns after edge 0 with inputs at the falling edge
    task automatic start_cycle(input logic e, input logic i, input logic m, input logic [1:0] s);
        @(negedge clk);
        cyc_start = 1'b1; cyc_ext = e; cyc_iack = i; ext_mon_en = m; ext_lim_sel = s;
        ack = 1'b0; arb_resp = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
    endtask

    // Drive ack/arb on chosen edges, record the pulse count and first edge
    task automatic watch(input int n, input int ack_e, input int arb_e,
                         output int errs, output int first);
        errs = 0; first = 0;
        for (int k = 1; k <= n; k++) begin
            ack = (k == ack_e);
            arb_resp = (k == arb_e);
            @(negedge clk);
            if (bus_err) begin
                errs++;
                if (first == 0) first = k;
            end
        end
        ack = 1'b0; arb_resp = 1'b0;
    endtask

    initial begin
        int errs, first;
        string tag;
        repeat (3) @(negedge clk);
        check("R9 reset holds error low", int'(bus_err), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle after reset", int'(bus_err), 0);

        for (int v = 0; v < NV; v++) begin
            start_cycle(VECS[v].ext, VECS[v].iack, VECS[v].mon, VECS[v].sel);
            watch(WATCH, int'(VECS[v].ack_edge), int'(VECS[v].arb_edge), errs, first);
            tag = $sformatf("R%0d vector %0d", VECS[v].req, v);
            check({tag, " pulse count"}, errs, (VECS[v].err_edge != 0) ? 1 : 0);
            check({tag, " error edge"}, first, int'(VECS[v].err_edge));
        end

        // R7: restart mid-cycle, single error 64 edges after the second start
        start_cycle(1'b0, 1'b0, 1'b1, 2'd0);
        watch(30, 0, 0, errs, first);
        check("R7 no error before restart", errs, 0);
        start_cycle(1'b0, 1'b0, 1'b1, 2'd0);
        watch(WATCH + 20, 0, 0, errs, first);
        check("R7 one pulse after restart", errs, 1);
        check("R7 error edge after restart", first, 64);

        // R8: attributes changed after the start edge are ignored
        start_cycle(1'b1, 1'b0, 1'b1, 2'd0);
        cyc_ext = 1'b0; ext_mon_en = 1'b0; ext_lim_sel = 2'd3; cyc_iack = 1'b1;
        watch(WATCH, 0, 0, errs, first);
        check("R8 latched limit edge", first, 8);
        check("R8 latched pulse count", errs, 1);

        // R9: reset during an open cycle abandons it
        start_cycle(1'b0, 1'b0, 1'b1, 2'd0);
        watch(10, 0, 0, errs, first);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 error low in reset", int'(bus_err), 0);
        rst_n = 1'b1;
        watch(WATCH, 0, 0, errs, first);
        check("R9 abandoned cycle silent", errs, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD_CYCLES, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule